// File: doc/BRIEF.md
# Vertical Sync Line Counter

This block generates the vertical sync waveform for a raster display. It does not count system clocks. Each state change is triggered by a one-cycle line-start strobe from the horizontal timing logic. Two lengths, both measured in lines, are captured once after reset:

- the number of lines for which sync is asserted;
- the number of lines for which sync stays idle.

From then on the frame pattern repeats forever without reloading. The default video mode uses 3 asserted lines and 497 idle lines, giving a 500-line frame. Those 500 lines are made up of 3 sync lines, 16 back-porch lines, 480 visible lines and 1 front-porch line.

The sync output is active low. A start-of-frame strobe marks the end of the asserted stretch, so it arrives once the sync lines of a frame have already gone by. Downstream logic uses this strobe to align its line count to the frame.

Top module: `vsync_line_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `vsync_n` is 1 and `frame_start` is 0.
- R2: Until a configuration has been captured, `vsync_n` stays 1, `frame_start` stays 0, and `line_start` pulses have no effect.
- R3: `vsync_n` changes value only in the cycle after a clock edge at which `line_start` was 1.
- R4: After configuration, the first counted `line_start` begins the asserted stretch. `vsync_n` reads 0 from the next cycle and stays 0 through the sync-length count of strobes. The following strobe drives it to 1, where it stays for the idle-length count of strobes.
- R5: `frame_start` is high for exactly one cycle, namely the cycle after the last asserted-line strobe of each frame, and `vsync_n` is still 0 in that cycle.
- R6: The first cycle with `cfg_load` high captures `cfg_sync_lines` and `cfg_idle_lines`. Every later `cfg_load` before the next reset is ignored.
- R7: The pattern repeats with a period of exactly sync-length plus idle-length strobes. No line is lost or counted twice where the counter wraps from one stretch to the next.
- R8: A configured length of 0 is captured as 1.
- R9: With a sync length of 1, the fall of `vsync_n` and the `frame_start` pulse come in the same cycle. This also holds when strobes arrive on consecutive cycles.
- R10: A `line_start` that arrives in the same cycle as the capturing `cfg_load` is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for the two line counts |
| cfg_sync_lines | input | LINE_W | Lines with sync asserted |
| cfg_idle_lines | input | LINE_W | Lines with sync idle |
| line_start | input | 1 | One-cycle strobe at each line start |
| vsync_n | output | 1 | Vertical sync, active low |
| frame_start | output | 1 | One-cycle start-of-frame strobe |

## Verification
The fall of `vsync_n` at the first line of a frame and the `frame_start` pulse at the last sync line are normally separate events. When the sync length is 1, both fall on the same strobe and must appear together in one cycle.

The bench provokes this case by loading a zero sync length, which is promoted to 1. It then issues strobes both with gaps between them and on back-to-back cycles. A scoreboard holds the expected `vsync_n` and `frame_start` value for every strobe and compares both in the cycle after it. Between strobes, it checks that `vsync_n` holds its value and that `frame_start` stays low.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
    // which stretch of the frame the next counted line belongs to
    typedef enum logic {
        PH_SYNC = 1'b0,
        PH_IDLE = 1'b1
    } vsl_phase_e;
endpackage

// File: rtl/vsl_cfg_store.sv
module vsl_cfg_store #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [LINE_W-1:0] cfg_sync_lines,
    input  logic [LINE_W-1:0] cfg_idle_lines,
    output logic              armed,
    output logic [LINE_W-1:0] sync_len,
    output logic [LINE_W-1:0] idle_len
);
    localparam logic [LINE_W-1:0] ONE = {{(LINE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              armed;
        logic [LINE_W-1:0] sync_len;
        logic [LINE_W-1:0] idle_len;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load && !st_q.armed) begin
            st_d.armed    = 1'b1;
            st_d.sync_len = (cfg_sync_lines == '0) ? ONE : cfg_sync_lines;
            st_d.idle_len = (cfg_idle_lines == '0) ? ONE : cfg_idle_lines;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0, sync_len: ONE, idle_len: ONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed    = st_q.armed;
    assign sync_len = st_q.sync_len;
    assign idle_len = st_q.idle_len;

    // R6: once captured, the lengths never move again
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed && $stable(sync_len) && $stable(idle_len));

    // R8: a stored length is never zero
    a_r8_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (sync_len != '0) && (idle_len != '0));
endmodule

// File: rtl/vsl_line_counter.sv
module vsl_line_counter
    import vsl_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] sync_len,
    input  logic [LINE_W-1:0] idle_len,
    output vsl_phase_e        phase,
    output logic              phase_done
);
    localparam logic [LINE_W-1:0] ONE = {{(LINE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        vsl_phase_e        phase;
        logic [LINE_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [LINE_W-1:0] cur_len;
    logic              at_last;
    logic              step;

    always_comb begin
        cur_len    = (ctr_q.phase == PH_SYNC) ? sync_len : idle_len;
        at_last    = (ctr_q.cnt == cur_len - ONE);
        step       = enable && line_tick;
        phase_done = step && at_last;
        ctr_d      = ctr_q;
        if (step) begin
            if (at_last) begin
                ctr_d.cnt   = '0;
                ctr_d.phase = (ctr_q.phase == PH_SYNC) ? PH_IDLE : PH_SYNC;
            end else begin
                ctr_d.cnt = ctr_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{phase: PH_SYNC, cnt: '0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign phase = ctr_q.phase;

    // R7: the position inside a stretch never reaches the stretch length
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (ctr_q.cnt < cur_len));

    // R7: finishing a stretch restarts the count in the other stretch
    a_r7_clean_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> (ctr_q.cnt == '0) && (ctr_q.phase != $past(ctr_q.phase)));

    // R2: the counter is frozen while disabled
    a_r2_frozen_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(ctr_q));
endmodule

// File: rtl/vsync_line_timer.sv
module vsync_line_timer
    import vsl_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [LINE_W-1:0] cfg_sync_lines,
    input  logic [LINE_W-1:0] cfg_idle_lines,
    input  logic              line_start,
    output logic              vsync_n,
    output logic              frame_start
);
    typedef struct packed {
        logic vsync_n;
        logic frame_start;
    } out_t;

    out_t              out_d, out_q;
    logic              armed;
    logic [LINE_W-1:0] sync_len;
    logic [LINE_W-1:0] idle_len;
    vsl_phase_e        phase;
    logic              phase_done;

    vsl_cfg_store #(.LINE_W(LINE_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_sync_lines(cfg_sync_lines),
        .cfg_idle_lines(cfg_idle_lines),
        .armed         (armed),
        .sync_len      (sync_len),
        .idle_len      (idle_len)
    );

    vsl_line_counter #(.LINE_W(LINE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (armed),
        .line_tick (line_start),
        .sync_len  (sync_len),
        .idle_len  (idle_len),
        .phase     (phase),
        .phase_done(phase_done)
    );

    always_comb begin
        out_d             = out_q;
        out_d.frame_start = 1'b0;
        if (armed && line_start) begin
            out_d.vsync_n     = (phase == PH_IDLE);
            out_d.frame_start = (phase == PH_SYNC) && phase_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{vsync_n: 1'b1, frame_start: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign vsync_n     = out_q.vsync_n;
    assign frame_start = out_q.frame_start;

    // R2: nothing is emitted before a configuration exists
    a_r2_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> vsync_n && !frame_start);

    // R3: a level change of vsync needs a counted strobe one edge earlier
    a_r3_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_n != $past(vsync_n)) |-> $past(line_start && armed));

    // R5: the frame strobe comes while sync is still asserted
    a_r5_sof_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !vsync_n);

    // R5: the frame strobe is a single cycle
    a_r5_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

// File: tb/vsync_line_timer_test.sv
module vsync_line_timer_test;
    localparam int LINE_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [LINE_W-1:0] cfg_sync_lines = '0;
    logic [LINE_W-1:0] cfg_idle_lines = '0;
    logic              line_start = 1'b0;
    logic              vsync_n;
    logic              frame_start;

    vsync_line_timer #(.LINE_W(LINE_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_sync_lines(cfg_sync_lines),
        .cfg_idle_lines(cfg_idle_lines),
        .line_start    (line_start),
        .vsync_n       (vsync_n),
        .frame_start   (frame_start)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int   due;
        logic vs;
        logic fs;
    } exp_t;

    exp_t exp_q[$];

    // reference model, built from the requirements
    logic m_armed;
    int   m_sync, m_idle, m_cnt;
    logic m_in_idle;
    logic m_vs;
    logic shown_vs;

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // monitor: compare due scoreboard items, otherwise check for quiet outputs
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R4 vsync_n after strobe", vsync_n, e.vs);
                check("R5 frame_start after strobe", frame_start, e.fs);
                shown_vs = e.vs;
            end else begin
                check("R3 vsync_n held between strobes", vsync_n, shown_vs);
                check("R5 frame_start low between strobes", frame_start, 1'b0);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        line_start = 1'b0;
        cfg_load = 1'b0;
        exp_q.delete();
        m_armed = 1'b0; m_sync = 1; m_idle = 1; m_cnt = 0;
        m_in_idle = 1'b0; m_vs = 1'b1; shown_vs = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 vsync_n in reset", vsync_n, 1'b1);
        check("R1 frame_start in reset", frame_start, 1'b0);
        rst_n = 1'b1;
    endtask

    function automatic void model_strobe(output logic vs, output logic fs);
        fs = 1'b0;
        if (m_armed) begin
            if (!m_in_idle) begin
                m_vs = 1'b0;
                if (m_cnt == m_sync - 1) begin
                    fs = 1'b1; m_cnt = 0; m_in_idle = 1'b1;
                end else m_cnt++;
            end else begin
                m_vs = 1'b1;
                if (m_cnt == m_idle - 1) begin
                    m_cnt = 0; m_in_idle = 1'b0;
                end else m_cnt++;
            end
        end
        vs = m_vs;
    endfunction

    // driver: one strobe, followed by gap quiet cycles
    task automatic strobe(input int gap);
        exp_t e;
        logic vs, fs;
        line_start = 1'b1;
        model_strobe(vs, fs);
        e.due = cyc + 1; e.vs = vs; e.fs = fs;
        exp_q.push_back(e);
        @(negedge clk);
        line_start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // R6 / R10: configuration, optionally with a coincident strobe
    task automatic configure(input int s, input int i, input logic with_strobe);
        exp_t e;
        cfg_load = 1'b1;
        cfg_sync_lines = LINE_W'(s);
        cfg_idle_lines = LINE_W'(i);
        line_start = with_strobe;
        if (with_strobe) begin
            e.due = cyc + 1; e.vs = m_vs; e.fs = 1'b0;  // R10: not counted
            exp_q.push_back(e);
        end
        if (!m_armed) begin
            m_armed = 1'b1;
            m_sync = (s == 0) ? 1 : s;   // R8
            m_idle = (i == 0) ? 1 : i;
        end
        @(negedge clk);
        cfg_load = 1'b0;
        line_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        @(negedge clk);
        // R1: first cycle after release
        check("R1 vsync_n after release", vsync_n, 1'b1);
        // R2: strobes before configuration are ignored
        for (int k = 0; k < 4; k++) strobe(1);
        // R10 + R6: configure 3/5 with a strobe in the same cycle
        configure(3, 5, 1'b1);
        // R4 R5 R7: three full frames with varied gaps
        for (int k = 0; k < 24; k++) strobe(k % 3);
        // R6: a second load must be ignored
        configure(2, 2, 1'b0);
        for (int k = 0; k < 16; k++) strobe(1);
        repeat (3) @(negedge clk);

        // R8 R9: zero lengths promoted to 1, sync length 1
        do_reset();
        configure(0, 0, 1'b0);
        for (int k = 0; k < 6; k++) strobe(2);
        repeat (3) @(negedge clk);

        // R9 R7: sync length 1 with back-to-back strobes
        do_reset();
        configure(1, 3, 1'b0);
        for (int k = 0; k < 12; k++) strobe(0);
        repeat (3) @(negedge clk);

        // R4 R7: default mode, 3 assert and 497 idle lines, two frames
        do_reset();
        configure(3, 497, 1'b0);
        for (int k = 0; k < 1003; k++) strobe(k % 2);
        repeat (4) @(negedge clk);

        check("R7 scoreboard drained", exp_q.size() == 0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule